// File: doc/BRIEF.md
# Legacy INTx Interrupt Aggregator

This block gathers the four level-sensitive legacy interrupt lines of a conventional PCI bus (INTA to INTD) and eight bus-error event pulses into a single interrupt request toward a parent interrupt controller. Each source has a sticky status bit and an enable bit. The registered output is high while any source has both its status bit and its enable bit set.

Software sees two 32-bit words through a simple register port with byte strobes. Word 0 is the shared control/status word. It holds the INTx status (write-one-to-clear), the INTx and error enables, a bus-request priority field and a TRDY wait field. The last two are plain storage for neighbouring logic. Word 1 holds the latched error-event status, also write-one-to-clear.

The INTx status field shares a word with the enables. Any read-modify-write of word 0 must therefore write zeros into bits 31..28, or it acknowledges pending lines by accident. The INTx inputs pass through a parameterised synchronizer. The error pulses are taken as already synchronous.

Top module: `legacy_irq_combiner`

## Requirements
- R1: After a synchronous reset, all enables, the priority and wait fields, and all status bits are zero, and `irq_o` is low.
- R2: A high INTx line `intx_i[k]` sets status bit 28+k of word 0 (INTA is k=0, bit 28), whether or not the line is enabled. With SYNC_STAGES=2 the bit is set on the third rising edge after the line goes high.
- R3: Writing word 0 with byte strobe 3 clears every status bit in 31..28 whose write data is 1. A 0 leaves the bit unchanged. Word 1 byte 0 does the same for the error status bits 7..0.
- R4: When a status bit is being set and cleared on the same edge, it ends up set.
- R5: `irq_o` is registered. One edge after the status or enables change, it equals the OR over all sources of (status AND enable).
- R6: Word 0 bits 25..22 enable INTA..INTD (bit 22 is INTA). Bit 27 enables error event 7 (command error) and bit 26 enables event 6 (parity error). Bits 21..16 enable events 5..0 (master abort received, target abort received, target abort sent, retry limit, SERR received, PERR received). A cleared enable masks its source.
- R7: A high `err_evt_i[j]` sets bit j of word 1 on the next rising edge. That bit feeds `irq_o` through its enable.
- R8: Word 0 bits 14..8 (priority) and 3..0 (wait) are read/write storage. Bits 15 and 7..4 always read 0.
- R9: A write changes only the bytes whose strobe is set. With no strobe set, a write changes nothing.
- R10: Writing 0xF000 to the upper halfword of word 0 (strobes 3 and 2) clears all four INTx status bits and all enables in bits 27..16.
- R11: A read access returns its data on `reg_rdata_o` after the next rising edge. The output holds its value while no read is made.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| intx_i | input | 4 | Legacy interrupt lines, bit 0 = INTA, active high |
| err_evt_i | input | 8 | Synchronous one-cycle bus error event pulses |
| reg_en_i | input | 1 | Register access strobe |
| reg_we_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | 1 | Word select: 0 control/status, 1 error status |
| reg_be_i | input | 4 | Byte strobes for writes |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Level interrupt request to the parent controller |

## Verification
The assertions assume that the error events arrive synchronous to `clk_i`, and that at most one register access is made per cycle, with the address limited to the two words. They also assume that reset is held for at least one edge before checking starts. The INTx lines may change at any time, because the synchronizer absorbs them. The stimulus drives every input on the falling edge. It generates error events only as single-cycle pulses, and it waits for the synchronizer to drain before it makes a clear that must not race a new set. The only deliberate race is the set-versus-clear case.

// File: rtl/lirq_pkg.sv
package lirq_pkg;
  localparam int REG_W      = 32;
  localparam int INTX_N     = 4;
  localparam int ERR_N      = 8;
  localparam int STORE_W    = 28;
  localparam int INTX_ST_LO = 28;
  localparam int INTX_EN_LO = 22;
  localparam int ERR_EN_LO  = 16;
  localparam int ERR_EN_PAR = 26;
  localparam int ERR_EN_CMD = 27;
  localparam int PRI_LO     = 8;
  localparam int PRI_W      = 7;
  localparam int WAIT_W     = 4;
  // implemented storage bits of word 0 below the status field
  localparam logic [STORE_W-1:0] STORE_MASK = 28'hFFF7F0F;

  typedef enum logic {
    WORD_CTRL = 1'b0,
    WORD_ERR  = 1'b1
  } word_sel_e;

  function automatic logic [ERR_N-1:0] err_enables(input logic [STORE_W-1:0] c);
    return {c[ERR_EN_CMD], c[ERR_EN_PAR], c[ERR_EN_LO +: 6]};
  endfunction
endpackage

// File: rtl/lirq_sync.sv
module lirq_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  generate
    if (STAGES == 0) begin : g_bypass
      assign q_o = d_i;
    end else begin : g_chain
      logic [W-1:0] stg_q [STAGES];
      always_ff @(posedge clk_i) begin
        if (rst_i) begin
          for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
        end else begin
          stg_q[0] <= d_i;
          for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
        end
      end
      assign q_o = stg_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/lirq_status.sv
module lirq_status #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] st_o
);
  logic [W-1:0] st_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) st_q <= '0;
    else       st_q <= (st_q & ~clr_i) | set_i;
  end
  assign st_o = st_q;

  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (rst_i)
    (set_i != '0) |=> ((st_q & $past(set_i)) == $past(set_i))); // R4
  AST_W1C_CLEARS: assert property (@(posedge clk_i) disable iff (rst_i)
    ((clr_i & ~set_i) != '0) |=> ((st_q & $past(clr_i & ~set_i)) == '0)); // R3
  AST_ST_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
    1'b1 |=> (((st_q ^ $past(st_q)) & ~$past(set_i | clr_i)) == '0)); // R3
endmodule

// File: rtl/lirq_ctrl.sv
module lirq_ctrl
  import lirq_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic               wr_i,
  input  logic [3:0]         be_i,
  input  logic [STORE_W-1:0] wdata_i,
  output logic [STORE_W-1:0] ctrl_o
);
  logic [STORE_W-1:0] lane_m;
  logic [STORE_W-1:0] wmask;
  logic [STORE_W-1:0] ctrl_q;

  genvar b;
  generate
    for (b = 0; b < STORE_W; b++) begin : g_lane
      assign lane_m[b] = be_i[b/8];
    end
  endgenerate

  assign wmask = wr_i ? (lane_m & STORE_MASK) : '0;

  always_ff @(posedge clk_i) begin
    if (rst_i) ctrl_q <= '0;
    else       ctrl_q <= (ctrl_q & ~wmask) | (wdata_i & wmask);
  end
  assign ctrl_o = ctrl_q;

  AST_IDLE_STABLE: assert property (@(posedge clk_i) disable iff (rst_i)
    !wr_i |=> $stable(ctrl_q)); // R9
  AST_NO_STROBE_STABLE: assert property (@(posedge clk_i) disable iff (rst_i)
    (be_i == 4'b0000) |=> $stable(ctrl_q)); // R9
endmodule

// File: rtl/legacy_irq_combiner.sv
module legacy_irq_combiner
  import lirq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [INTX_N-1:0] intx_i,
  input  logic [ERR_N-1:0]  err_evt_i,
  input  logic              reg_en_i,
  input  logic              reg_we_i,
  input  logic              reg_addr_i,
  input  logic [3:0]        reg_be_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  output logic              irq_o
);
  logic [INTX_N-1:0]  intx_s;
  logic [INTX_N-1:0]  intx_st;
  logic [INTX_N-1:0]  intx_clr;
  logic [INTX_N-1:0]  intx_en;
  logic [ERR_N-1:0]   err_st;
  logic [ERR_N-1:0]   err_clr;
  logic [ERR_N-1:0]   err_en;
  logic [STORE_W-1:0] ctrl;
  logic               wr_ctrl, wr_err, rd_any;
  logic               irq_q;
  logic [REG_W-1:0]   rdata_q;

  assign wr_ctrl = reg_en_i &  reg_we_i & (reg_addr_i == WORD_CTRL);
  assign wr_err  = reg_en_i &  reg_we_i & (reg_addr_i == WORD_ERR);
  assign rd_any  = reg_en_i & ~reg_we_i;

  assign intx_clr = (wr_ctrl && reg_be_i[3]) ? reg_wdata_i[INTX_ST_LO +: INTX_N] : '0;
  assign err_clr  = (wr_err  && reg_be_i[0]) ? reg_wdata_i[ERR_N-1:0]            : '0;

  lirq_sync #(.W(INTX_N), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i (clk_i), .rst_i (rst_i), .d_i (intx_i), .q_o (intx_s)
  );

  lirq_status #(.W(INTX_N)) i_intx_st (
    .clk_i (clk_i), .rst_i (rst_i), .set_i (intx_s), .clr_i (intx_clr), .st_o (intx_st)
  );

  lirq_status #(.W(ERR_N)) i_err_st (
    .clk_i (clk_i), .rst_i (rst_i), .set_i (err_evt_i), .clr_i (err_clr), .st_o (err_st)
  );

  lirq_ctrl i_ctrl (
    .clk_i (clk_i), .rst_i (rst_i), .wr_i (wr_ctrl), .be_i (reg_be_i),
    .wdata_i (reg_wdata_i[STORE_W-1:0]), .ctrl_o (ctrl)
  );

  assign intx_en = ctrl[INTX_EN_LO +: INTX_N];
  assign err_en  = err_enables(ctrl);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      irq_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      irq_q <= (|(intx_st & intx_en)) | (|(err_st & err_en));
      if (rd_any) begin
        if (reg_addr_i == WORD_ERR) rdata_q <= {{(REG_W-ERR_N){1'b0}}, err_st};
        else                        rdata_q <= {intx_st, ctrl};
      end
    end
  end

  assign irq_o       = irq_q;
  assign reg_rdata_o = rdata_q;

  AST_IRQ_MASKED: assert property (@(posedge clk_i) disable iff (rst_i)
    (((intx_st & intx_en) == '0) && ((err_st & err_en) == '0)) |=> !irq_o); // R5
  AST_IRQ_RAISED: assert property (@(posedge clk_i) disable iff (rst_i)
    ((intx_st & intx_en) != '0) |=> irq_o); // R5
  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
    !rd_any |=> $stable(reg_rdata_o)); // R11
  AST_CLEAR_ALL: assert property (@(posedge clk_i) disable iff (rst_i)
    (wr_ctrl && reg_be_i[3:2] == 2'b11 && reg_wdata_i[31:16] == 16'hF000 && intx_s == '0)
    |=> (intx_st == '0 && ctrl[27:16] == '0)); // R10
endmodule

// File: tb/test_legacy_irq_combiner.sv
`timescale 1ns/100ps
module test_legacy_irq_combiner;
  logic        clk = 1'b0;
  logic        rst;
  logic [3:0]  intx;
  logic [7:0]  evt;
  logic        en, we, addr;
  logic [3:0]  be;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        irq;
  int          checks = 0;
  int          fails  = 0;
  bit          done   = 1'b0;

  always #2.5 clk = ~clk;

  legacy_irq_combiner #(.SYNC_STAGES(2)) i_legacy_irq_combiner (
    .clk_i (clk), .rst_i (rst), .intx_i (intx), .err_evt_i (evt),
    .reg_en_i (en), .reg_we_i (we), .reg_addr_i (addr), .reg_be_i (be),
    .reg_wdata_i (wdata), .reg_rdata_o (rdata), .irq_o (irq)
  );

  // {byte strobes, write data, expected word 0 readback}
  localparam logic [67:0] TBL [8] = '{
    {4'hF, 32'hFFFFFFFF, 32'h0FFF7F0F},
    {4'h1, 32'h00000000, 32'h0FFF7F00},
    {4'h2, 32'h00000A00, 32'h0FFF0A00},
    {4'h4, 32'h00550000, 32'h0F550A00},
    {4'h8, 32'h03000000, 32'h03550A00},
    {4'hC, 32'hF0000000, 32'h00000A00},
    {4'h0, 32'hFFFFFFFF, 32'h00000A00},
    {4'h3, 32'h0000F0F5, 32'h00007005}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [3:0] b, input logic [31:0] d);
    @(negedge clk);
    en = 1'b1; we = 1'b1; addr = a; be = b; wdata = d;
    @(negedge clk);
    en = 1'b0; we = 1'b0; be = 4'h0;
  endtask

  task automatic rd(input logic a, output logic [31:0] d);
    @(negedge clk);
    en = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    en = 1'b0;
    d = rdata;
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_evt(input int j);
    @(negedge clk);
    evt[j] = 1'b1;
    @(negedge clk);
    evt = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    rst = 1'b1; intx = '0; evt = '0; en = 1'b0; we = 1'b0; addr = 1'b0; be = '0; wdata = '0;
    cycles(4);
    rst = 1'b0;
    cycles(1);

    // R1 reset state
    check("R1 irq", {31'b0, irq}, 32'h0);
    rd(1'b0, v); check("R1 word0", v, 32'h0);
    rd(1'b1, v); check("R1 word1", v, 32'h0);

    // R8 R9 R10 table of field writes
    for (int i = 0; i < 8; i++) begin
      wr(1'b0, TBL[i][67:64], TBL[i][63:32]);
      rd(1'b0, v);
      check($sformatf("R8/R9/R10 vec%0d", i), v, TBL[i][31:0]);
    end

    // R2: masked line still latches; R5: no irq when masked
    @(negedge clk); intx = 4'b0010;
    @(negedge clk); intx = '0;
    cycles(4);
    check("R5 masked irq", {31'b0, irq}, 32'h0);
    rd(1'b0, v); check("R2 INTB latched", v, 32'h20007005);

    // R3 write zero keeps, write one clears
    wr(1'b0, 4'h8, 32'h00000000);
    rd(1'b0, v); check("R3 write0 keeps", v, 32'h20007005);
    wr(1'b0, 4'h8, 32'h20000000);
    rd(1'b0, v); check("R3 write1 clears", v, 32'h00007005);

    // R5 R6 timing with INTB enabled (bit 23)
    wr(1'b0, 4'h4, 32'h00800000);
    @(negedge clk); intx = 4'b0010;
    @(negedge clk); intx = '0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R2 irq not before status edge", {31'b0, irq}, 32'h0);
    @(negedge clk);
    check("R5 irq one edge after status", {31'b0, irq}, 32'h1);
    wr(1'b0, 4'h8, 32'h20000000);
    check("R5 irq still high at clear edge", {31'b0, irq}, 32'h1);
    @(negedge clk);
    check("R3 irq low after clear", {31'b0, irq}, 32'h0);

    // R4 set beats clear while INTA held
    @(negedge clk); intx = 4'b0001;
    cycles(4);
    wr(1'b0, 4'h8, 32'h10000000);
    rd(1'b0, v); check("R4 set wins", v, 32'h10807005);
    @(negedge clk); intx = '0;
    cycles(4);
    wr(1'b0, 4'h8, 32'h10000000);
    rd(1'b0, v); check("R4 clear after release", v, 32'h00807005);

    // R7 error events, R6 error enables
    pulse_evt(5);
    rd(1'b1, v); check("R7 master abort latched", v, 32'h00000020);
    check("R6 event masked", {31'b0, irq}, 32'h0);
    wr(1'b0, 4'h4, 32'h00A00000);
    @(negedge clk);
    check("R6 R7 event enabled irq", {31'b0, irq}, 32'h1);
    wr(1'b1, 4'h1, 32'h00000020);
    @(negedge clk);
    rd(1'b1, v); check("R3 word1 clear", v, 32'h0);
    check("R7 irq low", {31'b0, irq}, 32'h0);
    wr(1'b0, 4'h8, 32'h08000000);
    pulse_evt(6);
    cycles(1);
    check("R6 parity masked", {31'b0, irq}, 32'h0);
    pulse_evt(7);
    cycles(1);
    check("R6 command error enabled", {31'b0, irq}, 32'h1);
    rd(1'b1, v); check("R7 word1 both", v, 32'h000000C0);

    // R10 clear-all halfword write with INTB pending
    @(negedge clk); intx = 4'b0010;
    @(negedge clk); intx = '0;
    cycles(4);
    wr(1'b0, 4'hC, 32'hF0000000);
    rd(1'b0, v); check("R10 word0 cleared", v, 32'h00007005);
    rd(1'b1, v); check("R10 word1 untouched", v, 32'h000000C0);
    check("R10 irq low", {31'b0, irq}, 32'h0);

    // R9 word1 strobes; R11 rdata holds without read
    wr(1'b1, 4'h0, 32'h000000FF);
    rd(1'b1, v); check("R9 no strobe no clear", v, 32'h000000C0);
    cycles(3);
    check("R11 rdata holds", rdata, 32'h000000C0);
    wr(1'b1, 4'h1, 32'h000000FF);
    rd(1'b1, v); check("R11 word1 read", v, 32'h0);

    // R1 reset from a loaded state
    wr(1'b0, 4'hF, 32'h0FFFFFFF);
    pulse_evt(0);
    @(negedge clk); rst = 1'b1;
    cycles(3);
    rst = 1'b0;
    rd(1'b0, v); check("R1 word0 after reset", v, 32'h0);
    rd(1'b1, v); check("R1 word1 after reset", v, 32'h0);
    check("R1 irq after reset", {31'b0, irq}, 32'h0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule